// File: doc/BRIEF.md
# Complementary Dead-Time Drive Generator

This block turns a single PWM pulse stream into complementary gate-drive signals for a set of half-bridge phase pairs (three by default). Each pair has an upper-side output, which is on while the PWM level is high, and a lower-side output, which is on while the PWM level is low. Every phase pair is fed from the same PWM input, so all pairs switch together.

At every PWM transition the side that is switching off drops at once. The side that is switching on is held off until a programmable dead interval has elapsed. That interval is timed by a down-counter. The counter is loaded from a 16-bit gap value and advances only on cycles where the prescale tick is high. If the PWM changes again before the interval runs out, the counter is reloaded for the new direction. The side that was waiting never turns on.

A polarity input picks whether the active drive level is 1 or 0. An enable input forces every output to its inactive level and clears the timer.

Top module: `deadband_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every output is at its inactive level and the timer holds zero.
- R2: When the registered PWM level rises, all lower-side outputs go inactive on the same clock edge that loads the timer. That edge is the second rising clock edge after `pwm_in` changes.
- R3: With the tick held high and gap value N, the upper-side outputs become active on the (N+3)th rising clock edge after `pwm_in` rises. In general they turn on at the edge of the first tick cycle in which the timer already reads zero.
- R4: A falling PWM edge behaves like R2 and R3 with the sides swapped. The upper side goes inactive at once, and the lower side turns on after the dead interval.
- R5: Any PWM edge, including one that arrives while a dead interval is still running, reloads the timer from `gap_val`. The side that was waiting under the previous edge never becomes active.
- R6: A gap value of zero still delays the turning-on side by one tick cycle after the timer load.
- R7: The timer changes only on tick cycles or at a PWM edge. With the tick low it holds its value and no side turns on.
- R8: With `act_high`=1 an active output reads 1. With `act_high`=0 every output is inverted, so an active output reads 0. A change of polarity shows on the outputs in the same cycle.
- R9: While `en` is low, the timer is cleared and all outputs go inactive on the next clock edge. After `en` rises, outputs stay inactive until the next PWM edge has run its dead interval.
- R10: The two outputs of a pair are never active at the same time.
- R11: All phase pairs carry identical drive values at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescale enable; the timer counts only when high |
| pwm_in | input | 1 | PWM pulse source |
| gap_val | input | CNT_W (16) | Dead interval reload value in ticks |
| act_high | input | 1 | 1: active level is 1; 0: active level is 0 |
| en | input | 1 | Enable; low forces all outputs inactive |
| drv_hi | output | NUM_PAIRS (3) | Upper-side drive outputs, one per pair |
| drv_lo | output | NUM_PAIRS (3) | Lower-side drive outputs, one per pair |

## Verification
On every cycle the assertions check four things. Pairs never overlap. The enable clears the outputs. Each edge turns both sides off and loads the timer with the gap value. An upper side turns on only after the timer has read zero, and the timer holds still on cycles without a tick.

The exact turn-on cycle for a given gap value can only be shown by the bench scenarios, which sample at counted clock edges. The same holds for the abandoned turn-on after a short pulse, the zero-gap case, the inversion of every output by the polarity input, and the reference model's cycle-by-cycle agreement.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

    typedef enum logic {
        SIDE_LO = 1'b0,
        SIDE_HI = 1'b1
    } side_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } drive_t;

    localparam drive_t DRIVE_OFF = '{hi: 1'b0, lo: 1'b0};

    // Map a logical "on" to the physical pin level for the chosen polarity.
    function automatic logic apply_pol(input logic on, input logic act_high);
        return act_high ? on : ~on;
    endfunction

endpackage

// File: rtl/db_edge_sync.sv
module db_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    output logic lvl,
    output logic edge_det
);
    logic lvl_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            lvl_q  <= pwm_in;
            prev_q <= lvl_q;
        end
    end

    assign lvl      = lvl_q;
    assign edge_det = lvl_q ^ prev_q;
endmodule

// File: rtl/db_delay_counter.sv
module db_delay_counter
    import deadband_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             edge_det,
    input  logic             lvl,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output drive_t           on
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    side_e            side_q;
    drive_t           on_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= CNT_ZERO;
            pend_q <= 1'b0;
            side_q <= SIDE_LO;
            on_q   <= DRIVE_OFF;
        end else if (edge_det) begin
            cnt_q  <= reload;
            pend_q <= 1'b1;
            side_q <= side_e'(lvl);
            on_q   <= DRIVE_OFF;
        end else if (pend_q && tick) begin
            if (cnt_q == CNT_ZERO) begin
                pend_q <= 1'b0;
                if (side_q == SIDE_HI) on_q.hi <= 1'b1;
                else                   on_q.lo <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

    assign cnt = cnt_q;
    assign on  = on_q;
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
    import deadband_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_PAIRS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 pwm_in,
    input  logic [CNT_W-1:0]     gap_val,
    input  logic                 act_high,
    input  logic                 en,
    output logic [NUM_PAIRS-1:0] drv_hi,
    output logic [NUM_PAIRS-1:0] drv_lo
);
    logic             lvl;
    logic             edge_det;
    logic [CNT_W-1:0] cnt_q;
    drive_t           on;

    db_edge_sync u_edge (
        .clk      (clk),
        .rst      (rst),
        .pwm_in   (pwm_in),
        .lvl      (lvl),
        .edge_det (edge_det)
    );

    db_delay_counter #(.CNT_W(CNT_W)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .edge_det (edge_det),
        .lvl      (lvl),
        .reload   (gap_val),
        .cnt      (cnt_q),
        .on       (on)
    );

    // One polarity stage per phase pair; all pairs share the single timer.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        assign drv_hi[g] = apply_pol(on.hi, act_high);
        assign drv_lo[g] = apply_pol(on.lo, act_high);
    end
endmodule

// File: rtl/db_checker.sv
module db_checker #(
    parameter int CNT_W     = 16,
    parameter int NUM_PAIRS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 tick,
    input logic                 act_high,
    input logic                 edge_det,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-1:0]     gap_val,
    input logic [NUM_PAIRS-1:0] drv_hi,
    input logic [NUM_PAIRS-1:0] drv_lo
);
    logic [NUM_PAIRS-1:0] act_hi;
    logic [NUM_PAIRS-1:0] act_lo;

    assign act_hi = act_high ? drv_hi : ~drv_hi;
    assign act_lo = act_high ? drv_lo : ~drv_lo;

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        (act_hi & act_lo) == '0);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (act_hi == '0 && act_lo == '0));

    // Covers R4 as well: both directions drop both sides at the load edge.
    assert_edge_turnoff_R2: assert property (@(posedge clk) disable iff (rst)
        (en && edge_det) |=> (act_hi == '0 && act_lo == '0));

    assert_edge_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (en && edge_det) |=> cnt == $past(gap_val));

    assert_tick_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !edge_det) |=> $stable(cnt));

    assert_on_after_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(act_hi[0]) |-> $past(cnt) == '0);
endmodule

bind deadband_gen db_checker #(.CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .tick     (tick),
    .act_high (act_high),
    .edge_det (edge_det),
    .cnt      (cnt_q),
    .gap_val  (gap_val),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo)
);

// File: tb/sim_deadband_gen.sv
module sim_deadband_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NP         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b1;
    logic          pwm_in = 1'b0;
    logic [CNT_W-1:0] gap_val = 16'd3;
    logic          act_high = 1'b1;
    logic          en = 1'b1;
    logic [NP-1:0] drv_hi;
    logic [NP-1:0] drv_lo;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deadband_gen #(.CNT_W(CNT_W), .NUM_PAIRS(NP)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .pwm_in(pwm_in), .gap_val(gap_val),
        .act_high(act_high), .en(en), .drv_hi(drv_hi), .drv_lo(drv_lo)
    );

    // Behavioural reference: integers stepped once per rising edge.
    int m_seen = 0, m_last = 0, m_wait = 0, m_cnt = 0, m_to_hi = 0;
    int m_hi = 0, m_lo = 0;

    always @(posedge clk) begin
        int nseen;
        int nlast;
        nseen = int'(pwm_in);
        nlast = m_seen;
        if (rst) begin
            m_seen = 0; m_last = 0; m_wait = 0; m_cnt = 0; m_hi = 0; m_lo = 0;
        end else begin
            if (!en) begin
                m_wait = 0; m_cnt = 0; m_hi = 0; m_lo = 0;
            end else if (m_seen != m_last) begin
                m_cnt = int'(gap_val); m_wait = 1; m_to_hi = m_seen;
                m_hi = 0; m_lo = 0;
            end else if (m_wait != 0 && tick) begin
                if (m_cnt == 0) begin
                    m_wait = 0;
                    if (m_to_hi != 0) m_hi = 1; else m_lo = 1;
                end else m_cnt = m_cnt - 1;
            end
            m_seen = nseen; m_last = nlast;
        end
    end

    function automatic logic [2*NP-1:0] phys(input int hi_on, input int lo_on);
        logic [NP-1:0] h;
        logic [NP-1:0] l;
        h = {NP{(hi_on != 0) ~^ act_high}};
        l = {NP{(lo_on != 0) ~^ act_high}};
        return {h, l};
    endfunction

    task automatic chk(input logic [2*NP-1:0] exp, input string tag);
        checks++;
        if ({drv_hi, drv_lo} !== exp) begin
            fails++;
            $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
                     tag, drv_hi, drv_lo, exp[2*NP-1:NP], exp[NP-1:0]);
        end
    endtask

    // Model comparison on every falling edge (R10 / R11 implied by shape).
    always @(negedge clk) begin
        if (!rst) chk(phys(m_hi, m_lo), "R10 R11 model");
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(phys(0, 0), "R1 reset idle");

        // Rising edge, gap 3: upper on at edge N+3 = 6
        pwm_in = 1'b1;
        cyc(5);
        chk(phys(0, 0), "R3 before expiry");
        cyc(1);
        chk(phys(1, 0), "R3 upper on");

        // Falling edge: upper off at edge 2, lower on at edge 6
        pwm_in = 1'b0;
        cyc(2);
        chk(phys(0, 0), "R4 upper off at load");
        cyc(3);
        chk(phys(0, 0), "R4 lower waiting");
        cyc(1);
        chk(phys(0, 1), "R4 lower on");

        // Rising edge turns lower off at once
        pwm_in = 1'b1;
        cyc(1);
        chk(phys(0, 1), "R2 before load");
        cyc(1);
        chk(phys(0, 0), "R2 lower off");
        cyc(5);
        chk(phys(1, 0), "R3 upper on again");

        // Short pulse: gap 10, low pulse of 4 cycles then high
        gap_val = 16'd10;
        pwm_in = 1'b0;
        cyc(4);
        pwm_in = 1'b1;
        cyc(3);
        chk(phys(0, 0), "R5 lower abandoned");
        cyc(9);
        chk(phys(0, 0), "R5 restarted wait");
        cyc(1);
        chk(phys(1, 0), "R5 upper after reload");

        // Zero gap: one tick of delay
        gap_val = 16'd0;
        pwm_in = 1'b0;
        cyc(2);
        chk(phys(0, 0), "R6 zero gap load");
        cyc(1);
        chk(phys(0, 1), "R6 zero gap one tick");

        // Tick gating
        gap_val = 16'd2;
        tick = 1'b0;
        pwm_in = 1'b1;
        cyc(10);
        chk(phys(0, 0), "R7 no tick holds");
        tick = 1'b1;
        cyc(2);
        chk(phys(0, 0), "R7 counting");
        cyc(1);
        chk(phys(1, 0), "R7 upper on");

        // Polarity inversion
        act_high = 1'b0;
        #1;
        chk({{NP{1'b0}}, {NP{1'b1}}}, "R8 inverted now");
        gap_val = 16'd1;
        pwm_in = 1'b0;
        cyc(2);
        chk({{NP{1'b1}}, {NP{1'b1}}}, "R8 both inactive high");
        cyc(2);
        chk({{NP{1'b1}}, {NP{1'b0}}}, "R8 lower active low");

        // Enable
        en = 1'b0;
        cyc(1);
        chk({{NP{1'b1}}, {NP{1'b1}}}, "R9 disabled");
        pwm_in = 1'b1;
        cyc(5);
        chk({{NP{1'b1}}, {NP{1'b1}}}, "R9 edge ignored");
        act_high = 1'b1;
        en = 1'b1;
        cyc(5);
        chk({{NP{1'b0}}, {NP{1'b0}}}, "R9 idle until edge");
        gap_val = 16'd3;
        pwm_in = 1'b0;
        cyc(6);
        chk({{NP{1'b0}}, {NP{1'b1}}}, "R9 resumes R11 pairs equal");

        cyc(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule